// File: doc/BRIEF.md
# Overflow-Interrupt Up-Counting Timer

A general-purpose timer whose counter runs upward in its own functional clock domain and flags an overflow whenever it wraps past the all-ones value. Software gets a delay of N ticks by writing all-ones minus N into the counter and then setting the run bit. The timer runs either once or periodically. In the one-shot case it stops itself after the wrap. In the auto-reload case it reloads from a separate load register and keeps running, so a steady tick train can be built by writing the load value first and then loading the counter and starting it.

Register writes arrive on a bus clock and are posted. Each write is held on the bus side and handed to the timer clock with a toggle handshake. While that handshake is in flight, a per-register pending bit shows in the status word. The counter is read back through a continuously refreshed snapshot that is carried safely into the bus clock. The interrupt line is the overflow flag gated by an enable bit, and software clears the flag with a write-one-to-clear.

Top module: `ovf_timer`

## Requirements
- R1: After reset every readable register (addresses 0 to 3) reads zero and `irq` is low.
- R2: The counter width is parameterised and is 32 bits by default. While the run bit (control bit 0, address 0) is set, the counter adds one on each timer clock. On a clock where it holds all-ones it wraps and sets the overflow flag (status bit 0, address 3). A counter written with all-ones minus N therefore flags after N+1 counting clocks.
- R3: In one-shot mode (auto-reload bit, control bit 1, clear) a wrap leaves the counter at zero and clears the run bit by itself.
- R4: In auto-reload mode a wrap copies the load register (address 1) into the counter and the timer keeps running.
- R5: Clearing the run bit freezes the counter value, and the load register changes only when it is written.
- R6: `irq` is high exactly when the overflow flag is set and the interrupt enable (control bit 2) is set.
- R7: Writing a one to status bit 0 clears the overflow flag. Writing zero there leaves it unchanged. A wrap in the same clock as the clear wins.
- R8: A write to address k sets status bit 8+k from the next bus clock until the value has been taken into the timer clock. A write reaches the timer registers on the third timer clock edge after the bus write edge.
- R9: A write to a register whose pending bit is set is dropped, and the earlier value stands.
- R10: A counter read (address 2) returns a snapshot captured in the timer clock and transferred whole into the bus clock. Once the counter has stopped, the snapshot settles on its exact value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| tmr_clk | input | 1 | Timer functional clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Write strobe, one bus clock per write |
| wr_addr | input | 2 | Write address: 0 control, 1 load, 2 counter, 3 status |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | CNT_W | Combinational read data |
| irq | output | 1 | Overflow interrupt, timer clock domain |

## Verification
The bench times a start from all-ones minus 20 up to the interrupt in timer clocks. A design that counts one short or long, or that applies writes with a different synchroniser depth, lands outside the window. After a one-shot wrap it expects the counter at zero and the run bit low; a design that reloads or keeps running shows a nonzero or moving count. It writes the load register twice back to back, and a design that accepts the second write during the handshake would read back the later value. It checks that a zero write to the status word keeps the flag, that the enable alone gates the line, and that a periodic run holds the counter inside the reload window while a stop freezes it and leaves the load value intact.

// File: rtl/ovt_pkg.sv
package ovt_pkg;
  localparam int NREG = 4;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_LOAD = 2'd1,
    A_CNT  = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;

  localparam int CB_RUN  = 0;
  localparam int CB_AUTO = 1;
  localparam int CB_IE   = 2;
  localparam int CTRL_W  = 3;
  localparam int SB_OVF  = 0;
  localparam int SB_PEND = 8;
endpackage

// File: rtl/ovt_rst_sync.sv
module ovt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_n = q[STAGES-1];
endmodule

// File: rtl/ovt_sync.sv
module ovt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ovt_post_chan.sv
// One posted register write path: bus-side holding register plus toggle handshake.
module ovt_post_chan #(
  parameter int W = 32
) (
  input  logic         bclk,
  input  logic         brst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         pending,
  output logic [W-1:0] data_o,
  input  logic         tclk,
  input  logic         trst_n,
  output logic         apply
);
  logic         req_q, req_d;
  logic [W-1:0] data_q, data_d;
  logic         ack_b;
  logic         req_t, req_t3;
  logic         accept;

  assign pending = req_q ^ ack_b;
  assign accept  = wr && !pending;

  always_comb begin
    req_d  = req_q ^ accept;
    data_d = accept ? wdata : data_q;
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      req_q  <= 1'b0;
      data_q <= '0;
    end else begin
      req_q  <= req_d;
      data_q <= data_d;
    end
  end

  ovt_sync #(.W(1), .STAGES(2)) u_req_sync (
    .clk(tclk), .rst_n(trst_n), .d(req_q), .q(req_t)
  );

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) req_t3 <= 1'b0;
    else         req_t3 <= req_t;
  end

  assign apply = req_t ^ req_t3;

  ovt_sync #(.W(1), .STAGES(2)) u_ack_sync (
    .clk(bclk), .rst_n(brst_n), .d(req_t3), .q(ack_b)
  );

  assign data_o = data_q;

  // R9
  drop_busy_wr_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    (wr && pending) |=> $stable(data_q));

  // R8
  pend_set_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    accept |=> pending);
endmodule

// File: rtl/ovt_snap.sv
// Counter snapshot: timer side captures on request, bus side refreshes shadow on ack.
module ovt_snap #(
  parameter int W = 32
) (
  input  logic         tclk,
  input  logic         trst_n,
  input  logic [W-1:0] live,
  input  logic         bclk,
  input  logic         brst_n,
  output logic [W-1:0] shadow
);
  logic         sreq_q, sreq_d;
  logic [W-1:0] shadow_q, shadow_d;
  logic         sack_b, done;
  logic         sreq_t, sreq_t3, cap;
  logic [W-1:0] snap_q, snap_d;

  assign done = (sack_b == sreq_q);

  always_comb begin
    sreq_d   = done ? ~sreq_q : sreq_q;
    shadow_d = done ? snap_q  : shadow_q;
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      sreq_q   <= 1'b0;
      shadow_q <= '0;
    end else begin
      sreq_q   <= sreq_d;
      shadow_q <= shadow_d;
    end
  end

  ovt_sync #(.W(1), .STAGES(2)) u_sreq_sync (
    .clk(tclk), .rst_n(trst_n), .d(sreq_q), .q(sreq_t)
  );

  assign cap    = sreq_t ^ sreq_t3;
  assign snap_d = cap ? live : snap_q;

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      sreq_t3 <= 1'b0;
      snap_q  <= '0;
    end else begin
      sreq_t3 <= sreq_t;
      snap_q  <= snap_d;
    end
  end

  ovt_sync #(.W(1), .STAGES(2)) u_sack_sync (
    .clk(bclk), .rst_n(brst_n), .d(sreq_t3), .q(sack_b)
  );

  assign shadow = shadow_q;

  // R10
  shadow_hold_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    !done |=> $stable(shadow_q));
endmodule

// File: rtl/ovt_core.sv
// Timer-domain state: counter, load, control bits, overflow flag.
module ovt_core #(
  parameter int W = 32
) (
  input  logic                       tclk,
  input  logic                       trst_n,
  input  logic                       apply_ctrl,
  input  logic [ovt_pkg::CTRL_W-1:0] ctrl_wd,
  input  logic                       apply_load,
  input  logic [W-1:0]               load_wd,
  input  logic                       apply_cnt,
  input  logic [W-1:0]               cnt_wd,
  input  logic                       apply_stat,
  input  logic                       clr_wd,
  output logic [W-1:0]               cnt_o,
  output logic                       run_o,
  output logic                       ovf_o,
  output logic                       irq_o
);
  import ovt_pkg::*;

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_nx, load_q, load_nx;
  logic         run_q, run_nx, auto_q, auto_nx, ie_q, ie_nx, ovf_q, ovf_nx;
  logic         wrap;

  assign wrap = run_q && (cnt_q == '1);

  always_comb begin
    cnt_nx  = cnt_q;
    load_nx = load_q;
    run_nx  = run_q;
    auto_nx = auto_q;
    ie_nx   = ie_q;
    ovf_nx  = ovf_q;
    if (run_q) cnt_nx = wrap ? (auto_q ? load_q : '0) : cnt_q + ONE;
    if (wrap && !auto_q) run_nx = 1'b0;
    if (apply_ctrl) begin
      run_nx  = ctrl_wd[CB_RUN];
      auto_nx = ctrl_wd[CB_AUTO];
      ie_nx   = ctrl_wd[CB_IE];
    end
    if (apply_load) load_nx = load_wd;
    if (apply_cnt)  cnt_nx  = cnt_wd;
    if (apply_stat && clr_wd) ovf_nx = 1'b0;
    if (wrap) ovf_nx = 1'b1;
  end

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
      run_q  <= 1'b0;
      auto_q <= 1'b0;
      ie_q   <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      load_q <= load_nx;
      run_q  <= run_nx;
      auto_q <= auto_nx;
      ie_q   <= ie_nx;
      ovf_q  <= ovf_nx;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
  assign ovf_o = ovf_q;
  assign irq_o = ovf_q && ie_q;

  // R2
  wrap_flag_chk: assert property (@(posedge tclk) disable iff (!trst_n)
    wrap |=> ovf_q);

  // R3
  oneshot_end_chk: assert property (@(posedge tclk) disable iff (!trst_n)
    (wrap && !auto_q && !apply_ctrl && !apply_cnt) |=> (!run_q && cnt_q == '0));

  // R4
  reload_chk: assert property (@(posedge tclk) disable iff (!trst_n)
    (wrap && auto_q && !apply_cnt) |=> (cnt_q == $past(load_q)));

  // R5
  hold_chk: assert property (@(posedge tclk) disable iff (!trst_n)
    (!run_q && !apply_cnt) |=> $stable(cnt_q));

  // R5
  load_keep_chk: assert property (@(posedge tclk) disable iff (!trst_n)
    !apply_load |=> $stable(load_q));

  // R7
  clear_chk: assert property (@(posedge tclk) disable iff (!trst_n)
    (apply_stat && clr_wd && !wrap) |=> !ovf_q);
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer #(
  parameter int CNT_W = 32
) (
  input  logic             bus_clk,
  input  logic             tmr_clk,
  input  logic             arst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  import ovt_pkg::*;

  logic             brst_n, trst_n;
  logic [NREG-1:0]  wsel, pend, apply;
  logic [CNT_W-1:0] data_ch [NREG];
  logic [CNT_W-1:0] cnt_live, cnt_shadow;
  logic             run_t, ovf_t, run_b, ovf_b;
  logic             unused_bits;

  ovt_rst_sync #(.STAGES(2)) u_brst (.clk(bus_clk), .arst_n(arst_n), .rst_n(brst_n));
  ovt_rst_sync #(.STAGES(2)) u_trst (.clk(tmr_clk), .arst_n(arst_n), .rst_n(trst_n));

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_chan
      assign wsel[g] = wr_en && (wr_addr == g[1:0]);
      ovt_post_chan #(.W(CNT_W)) u_chan (
        .bclk(bus_clk), .brst_n(brst_n), .wr(wsel[g]), .wdata(wr_data),
        .pending(pend[g]), .data_o(data_ch[g]),
        .tclk(tmr_clk), .trst_n(trst_n), .apply(apply[g])
      );
    end
  endgenerate

  ovt_core #(.W(CNT_W)) u_core (
    .tclk(tmr_clk), .trst_n(trst_n),
    .apply_ctrl(apply[A_CTRL]), .ctrl_wd(data_ch[A_CTRL][CTRL_W-1:0]),
    .apply_load(apply[A_LOAD]), .load_wd(data_ch[A_LOAD]),
    .apply_cnt(apply[A_CNT]),   .cnt_wd(data_ch[A_CNT]),
    .apply_stat(apply[A_STAT]), .clr_wd(data_ch[A_STAT][SB_OVF]),
    .cnt_o(cnt_live), .run_o(run_t), .ovf_o(ovf_t), .irq_o(irq)
  );

  ovt_snap #(.W(CNT_W)) u_snap (
    .tclk(tmr_clk), .trst_n(trst_n), .live(cnt_live),
    .bclk(bus_clk), .brst_n(brst_n), .shadow(cnt_shadow)
  );

  ovt_sync #(.W(2), .STAGES(2)) u_stat_sync (
    .clk(bus_clk), .rst_n(brst_n), .d({run_t, ovf_t}), .q({run_b, ovf_b})
  );

  assign unused_bits = ^{data_ch[A_CTRL][CNT_W-1:CTRL_W], data_ch[A_STAT][CNT_W-1:1]};

  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(rd_addr))
      A_CTRL: begin
        rd_data[CB_RUN]  = run_b;
        rd_data[CB_AUTO] = data_ch[A_CTRL][CB_AUTO];
        rd_data[CB_IE]   = data_ch[A_CTRL][CB_IE];
      end
      A_LOAD: rd_data = data_ch[A_LOAD];
      A_CNT:  rd_data = cnt_shadow;
      default: begin
        rd_data[SB_OVF] = ovf_b;
        rd_data[SB_PEND +: NREG] = pend;
      end
    endcase
  end
endmodule

// File: tb/tb_ovf_timer.sv
`timescale 1ns/1ps
module tb_ovf_timer;
  localparam logic [31:0] ALL1 = 32'hFFFF_FFFF;
  localparam logic [1:0] AC = 2'd0, AL = 2'd1, AN = 2'd2, AS = 2'd3;

  logic        bus_clk = 1'b0, tmr_clk = 1'b0, arst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [1:0]  a_q[$];
  logic [31:0] lo_q[$], hi_q[$], m_q[$];
  string       t_q[$];

  ovf_timer #(.CNT_W(32)) dut (
    .bus_clk(bus_clk), .tmr_clk(tmr_clk), .arst_n(arst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #2.5 bus_clk = ~bus_clk;
  initial begin
    #1.3;
    forever #3.5 tmr_clk = ~tmr_clk;
  end

  // monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      @(negedge bus_clk);
      if (a_q.size() > 0) begin
        logic [31:0] act;
        rd_addr = a_q[0];
        #1;
        act = rd_data & m_q[0];
        n_chk++;
        if (act < lo_q[0] || act > hi_q[0]) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h..%h", t_q[0], act, lo_q[0], hi_q[0]);
        end
        void'(a_q.pop_front()); void'(lo_q.pop_front()); void'(hi_q.pop_front());
        void'(m_q.pop_front()); void'(t_q.pop_front());
      end
    end
  end

  task automatic expect_rd(input logic [1:0] a, input logic [31:0] lo, input logic [31:0] hi,
                           input logic [31:0] m, input string tag);
    a_q.push_back(a); lo_q.push_back(lo); hi_q.push_back(hi); m_q.push_back(m); t_q.push_back(tag);
    while (a_q.size() != 0) @(posedge bus_clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_now(input logic [1:0] a, output logic [31:0] v);
    @(negedge bus_clk);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    do rd_now(AS, v); while (v[11:8] != 4'd0);
    repeat (20) @(negedge bus_clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v1;
    int n;
    repeat (10) @(negedge bus_clk);
    arst_n = 1'b1;
    repeat (10) @(negedge bus_clk);

    // R1 reset state
    expect_rd(AC, 0, 0, ALL1, "R1 ctrl");
    expect_rd(AL, 0, 0, ALL1, "R1 load");
    expect_rd(AN, 0, 0, ALL1, "R1 count");
    expect_rd(AS, 0, 0, ALL1, "R1 status");
    check(irq == 1'b0, "R1 irq", {31'b0, irq}, 0);

    // R8 pending bit for the counter write (bit 10)
    bus_write(AN, 32'hFFFF_FFF0);
    expect_rd(AS, 32'h400, 32'h400, 32'h400, "R8 pending set");
    wait_idle();
    expect_rd(AS, 0, 0, 32'hF00, "R8 pending clear");
    // R10 stopped counter snapshot exact
    expect_rd(AN, 32'hFFFF_FFF0, 32'hFFFF_FFF0, ALL1, "R10 snapshot");

    // R9 second write while pending is dropped
    bus_write(AL, 32'd5);
    bus_write(AL, 32'd7);
    wait_idle();
    expect_rd(AL, 5, 5, ALL1, "R9 dropped write");

    // R2/R8 one-shot delay of 20: flag after 21 counts plus 3-edge transfer
    bus_write(AN, ALL1 - 32'd20);
    wait_idle();
    bus_write(AC, 32'h5);
    n = 0;
    while (!irq && n < 100) begin
      @(posedge tmr_clk); #1; n++;
    end
    check(n >= 22 && n <= 26, "R2 R8 delay edges", n, 24);
    wait_idle();
    // R3 one-shot end
    expect_rd(AC, 4, 4, ALL1, "R3 run self-clear");
    expect_rd(AN, 0, 0, ALL1, "R3 count at zero");
    expect_rd(AS, 1, 1, 1, "R2 flag set");

    // R7 zero write keeps flag, one write clears
    bus_write(AS, 32'h0);
    wait_idle();
    expect_rd(AS, 1, 1, 1, "R7 zero write");
    check(irq == 1'b1, "R7 irq kept", {31'b0, irq}, 1);
    bus_write(AS, 32'h1);
    wait_idle();
    expect_rd(AS, 0, 0, 1, "R7 clear");
    check(irq == 1'b0, "R7 irq low", {31'b0, irq}, 0);

    // R6 enable gates irq
    bus_write(AC, 32'h0);
    wait_idle();
    bus_write(AN, ALL1 - 32'd5);
    wait_idle();
    bus_write(AC, 32'h1);
    repeat (40) @(negedge tmr_clk);
    wait_idle();
    expect_rd(AS, 1, 1, 1, "R6 flag without enable");
    check(irq == 1'b0, "R6 irq masked", {31'b0, irq}, 0);
    bus_write(AC, 32'h4);
    wait_idle();
    check(irq == 1'b1, "R6 irq enabled", {31'b0, irq}, 1);
    bus_write(AS, 32'h1);
    wait_idle();

    // R4 periodic: load first, then counter, then start with auto-reload
    bus_write(AL, 32'hFFFF_FFF6);
    wait_idle();
    bus_write(AN, 32'hFFFF_FFF6);
    wait_idle();
    bus_write(AC, 32'h7);
    repeat (60) @(negedge tmr_clk);
    expect_rd(AC, 7, 7, ALL1, "R4 still running");
    expect_rd(AN, 32'hFFFF_FFF6, ALL1, ALL1, "R4 window a");
    repeat (7) @(negedge bus_clk);
    expect_rd(AN, 32'hFFFF_FFF6, ALL1, ALL1, "R4 window b");
    expect_rd(AS, 1, 1, 1, "R4 flag");

    // R5 stop freezes count, keeps load
    bus_write(AC, 32'h0);
    wait_idle();
    rd_now(AN, v1);
    check(v1 >= 32'hFFFF_FFF6, "R5 stopped in window", v1, 32'hFFFF_FFF6);
    repeat (30) @(negedge bus_clk);
    expect_rd(AN, v1, v1, ALL1, "R5 frozen count");
    expect_rd(AL, 32'hFFFF_FFF6, 32'hFFFF_FFF6, ALL1, "R5 load kept");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule